// File: doc/BRIEF.md
# Desaturation Fault Protection Sequencer

This block sequences the digital side of an IGBT gate driver's short-circuit protection. A PWM command turns the gate on and off while the output-side supply is reported good. After every turn-on, a blanking window hides the desaturation comparator while the collector voltage settles. A comparator hit after that window starts a protective shutdown. The main driver is released to high impedance and the gate is discharged slowly through a soft-shutdown path. When a gate-low comparator reports that the gate has fallen, the Miller clamp takes over from the soft-shutdown path.

An active-low fault flag reports the event. While the fault is active, the PWM input is muted for a fixed interval. After that interval, the fault clears only once the PWM input has stayed low for a full qualification interval. A high sample during qualification restarts that interval from zero. All intervals are counted in clock cycles through parameters. Analog sensing, current sources and comparators lie outside the block and reach it as synchronous flags.

Top module: `desat_guard`

## Requirements
- R1: While reset is asserted and right after it, gate_on, ssd_en and drv_hiz are 0, fault_n is 1, and clamp_en follows gate_low.
- R2: With supply_ok high and no fault active, gate_on follows pwm_in one clock later, in both directions.
- R3: A low supply_ok forces gate_on to 0 one clock later and keeps it there whatever pwm_in does. Desaturation is not sampled during that time.
- R4: desat_hi is ignored while the gate is off and during the first BLANK_CYC clocks of each on-period.
- R5: A high desat_hi sampled while the gate is on and blanking is over drives fault_n to 0, gate_on to 0, drv_hiz to 1 and ssd_en to 1 one clock later.
- R6: ssd_en stays high until gate_low is sampled high. One clock after that, ssd_en is 0 and clamp_en is 1. clamp_en and ssd_en are never high together.
- R7: For MUTE_CYC clocks from fault entry, pwm_in has no effect: gate_on stays 0, drv_hiz stays 1 and fault_n stays 0.
- R8: When pwm_in is low and gate_low is high throughout, fault_n returns to 1 and drv_hiz to 0 exactly MUTE_CYC+RST_CYC clocks after fault entry.
- R9: A high pwm_in sample during qualification restarts it, so clearing needs RST_CYC further consecutive low samples.
- R10: After the fault clears, a high pwm_in turns the gate on again one clock later.
- R11: Outside a fault, clamp_en equals gate_low while the gate is off and is 0 while it is on. gate_on and clamp_en are never both 1.
- R12: If pwm_in is held high through the whole mute interval, the fault stays active until pwm_in falls. It then clears after RST_CYC low samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| pwm_in | input | 1 | Gate command, 1 = on |
| supply_ok | input | 1 | Output-side supply above its lockout threshold |
| desat_hi | input | 1 | Desaturation comparator: collector sense above threshold |
| gate_low | input | 1 | Gate voltage below clamp threshold |
| gate_on | output | 1 | Drive main output high |
| ssd_en | output | 1 | Enable slow gate discharge path |
| clamp_en | output | 1 | Enable Miller clamp pull-down |
| drv_hiz | output | 1 | Release main output driver to high impedance |
| fault_n | output | 1 | Fault flag, 0 = fault active |

## Verification
A wrong state in the sequencer shows up at the ports within one clock. The outputs are decoded directly from the state register, so a state error gives a wrong mix of gate_on, ssd_en, clamp_en and drv_hiz on the next cycle. Timer errors are subtler: they only move the edge of fault_n or the first sensing cycle. Those edges are therefore checked on the exact cycle on both sides: one cycle before the expected clear and on the clearing cycle, and at the last blanked cycle and the first sensed one. A restarted or unrestarted qualification count then appears as a clear that lands early or late by a known number of clocks.

// File: rtl/dsg_pkg.sv
package dsg_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_BLANK = 3'd1,
    ST_SENSE = 3'd2,
    ST_SSD   = 3'd3,
    ST_MUTE  = 3'd4,
    ST_QUAL  = 3'd5
  } dsg_state_e;

  function automatic logic in_fault(input dsg_state_e s);
    return (s == ST_SSD) || (s == ST_MUTE) || (s == ST_QUAL);
  endfunction

endpackage

// File: rtl/dsg_timer.sv
module dsg_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic done
);

  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign done = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (en && !done) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/dsg_fsm.sv
module dsg_fsm
  import dsg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_in,
  input  logic       supply_ok,
  input  logic       desat_hi,
  input  logic       gate_low,
  input  logic       blank_done,
  input  logic       mute_done,
  input  logic       qual_done,
  output dsg_state_e state_q
);

  dsg_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF: begin
        if (pwm_in && supply_ok) state_d = ST_BLANK;
      end
      ST_BLANK: begin
        if (!pwm_in || !supply_ok) state_d = ST_OFF;
        else if (blank_done)       state_d = ST_SENSE;
      end
      ST_SENSE: begin
        if (!supply_ok)    state_d = ST_OFF;
        else if (desat_hi) state_d = ST_SSD;
        else if (!pwm_in)  state_d = ST_OFF;
      end
      ST_SSD: begin
        if (gate_low) state_d = ST_MUTE;
      end
      ST_MUTE: begin
        if (mute_done) state_d = ST_QUAL;
      end
      ST_QUAL: begin
        if (qual_done && !pwm_in) state_d = ST_OFF;
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/dsg_outdec.sv
module dsg_outdec
  import dsg_pkg::*;
(
  input  dsg_state_e state,
  input  logic       gate_low,
  output logic       gate_on,
  output logic       ssd_en,
  output logic       clamp_en,
  output logic       drv_hiz,
  output logic       fault_n
);

  always_comb begin
    gate_on  = 1'b0;
    ssd_en   = 1'b0;
    clamp_en = 1'b0;
    drv_hiz  = 1'b0;
    fault_n  = 1'b1;
    unique case (state)
      ST_OFF:   clamp_en = gate_low;
      ST_BLANK: gate_on  = 1'b1;
      ST_SENSE: gate_on  = 1'b1;
      ST_SSD: begin
        ssd_en  = 1'b1;
        drv_hiz = 1'b1;
        fault_n = 1'b0;
      end
      ST_MUTE, ST_QUAL: begin
        clamp_en = 1'b1;
        drv_hiz  = 1'b1;
        fault_n  = 1'b0;
      end
      default: begin
        drv_hiz = 1'b1;
        fault_n = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/desat_guard.sv
module desat_guard
  import dsg_pkg::*;
#(
  parameter int BLANK_CYC = 8,
  parameter int MUTE_CYC  = 40,
  parameter int RST_CYC   = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_in,
  input  logic supply_ok,
  input  logic desat_hi,
  input  logic gate_low,
  output logic gate_on,
  output logic ssd_en,
  output logic clamp_en,
  output logic drv_hiz,
  output logic fault_n
);

  dsg_state_e state;
  logic       blank_done;
  logic       mute_done;
  logic       qual_done;
  logic       in_blank;
  logic       in_mute;
  logic       in_qual;

  assign in_blank = (state == ST_BLANK);
  assign in_mute  = (state == ST_SSD) || (state == ST_MUTE);
  assign in_qual  = (state == ST_QUAL);

  dsg_timer #(.LIMIT(BLANK_CYC)) u_blank (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!in_blank),
    .en    (in_blank),
    .done  (blank_done)
  );

  dsg_timer #(.LIMIT(MUTE_CYC)) u_mute (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!in_mute),
    .en    (in_mute),
    .done  (mute_done)
  );

  dsg_timer #(.LIMIT(RST_CYC)) u_qual (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!in_qual || pwm_in),
    .en    (in_qual),
    .done  (qual_done)
  );

  dsg_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_in     (pwm_in),
    .supply_ok  (supply_ok),
    .desat_hi   (desat_hi),
    .gate_low   (gate_low),
    .blank_done (blank_done),
    .mute_done  (mute_done),
    .qual_done  (qual_done),
    .state_q    (state)
  );

  dsg_outdec u_dec (
    .state    (state),
    .gate_low (gate_low),
    .gate_on  (gate_on),
    .ssd_en   (ssd_en),
    .clamp_en (clamp_en),
    .drv_hiz  (drv_hiz),
    .fault_n  (fault_n)
  );

  p_gate_clamp_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_on && clamp_en));

  p_ssd_clamp_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ssd_en && clamp_en));

  p_ssd_handover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ssd_en && gate_low) |=> (!ssd_en && clamp_en));

  p_ssd_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ssd_en |-> (drv_hiz && !fault_n));

  p_fault_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_n) |-> ($past(desat_hi) && $past(gate_on)));

  p_muted_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fault_n |-> !gate_on);

  p_clear_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_n) |-> !$past(pwm_in));

  p_supply_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !gate_on);

endmodule

// File: tb/desat_guard_tb.sv
module desat_guard_tb;

  localparam int BLANK = 8;
  localparam int MUTE  = 40;
  localparam int RST   = 24;

  logic clk = 1'b0;
  logic rst_n;
  logic pwm_in, supply_ok, desat_hi, gate_low;
  logic gate_on, ssd_en, clamp_en, drv_hiz, fault_n;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  desat_guard #(.BLANK_CYC(BLANK), .MUTE_CYC(MUTE), .RST_CYC(RST)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .supply_ok(supply_ok),
    .desat_hi(desat_hi), .gate_low(gate_low), .gate_on(gate_on),
    .ssd_en(ssd_en), .clamp_en(clamp_en), .drv_hiz(drv_hiz), .fault_n(fault_n)
  );

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Turns the gate on with desat high; returns on the first negedge with the fault visible.
  task automatic trigger_fault(input logic pwm_after, input logic glow_after);
    pwm_in = 1'b1; desat_hi = 1'b1; gate_low = 1'b0;
    tick(BLANK + 1);
    chk("R4", "fault_n last blanked", fault_n, 1'b1);
    tick(1);
    chk("R5", "fault_n", fault_n, 1'b0);
    chk("R5", "gate_on", gate_on, 1'b0);
    chk("R5", "ssd_en", ssd_en, 1'b1);
    chk("R5", "drv_hiz", drv_hiz, 1'b1);
    desat_hi = 1'b0; pwm_in = pwm_after; gate_low = glow_after;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pwm_in = 1'b0; supply_ok = 1'b1; desat_hi = 1'b0; gate_low = 1'b1;
    tick(3);
    chk("R1", "clamp_en in reset", clamp_en, 1'b1);
    rst_n = 1'b1;
    tick(1);
    chk("R1", "gate_on", gate_on, 1'b0);
    chk("R1", "fault_n", fault_n, 1'b1);
    chk("R1", "ssd_en", ssd_en, 1'b0);
    chk("R1", "drv_hiz", drv_hiz, 1'b0);
  endtask

  task automatic t_drive();
    pwm_in = 1'b1; gate_low = 1'b0;
    tick(1);
    chk("R2", "gate_on rise", gate_on, 1'b1);
    chk("R11", "clamp_en while on", clamp_en, 1'b0);
    pwm_in = 1'b0;
    tick(1);
    chk("R2", "gate_on fall", gate_on, 1'b0);
    chk("R11", "clamp_en gate not low", clamp_en, 1'b0);
    gate_low = 1'b1;
    tick(1);
    chk("R11", "clamp_en gate low", clamp_en, 1'b1);
  endtask

  task automatic t_supply();
    pwm_in = 1'b1; gate_low = 1'b0;
    tick(1);
    chk("R3", "gate_on before loss", gate_on, 1'b1);
    supply_ok = 1'b0; desat_hi = 1'b1;
    tick(1);
    chk("R3", "gate_on after loss", gate_on, 1'b0);
    tick(4);
    chk("R3", "gate_on held off", gate_on, 1'b0);
    chk("R3", "no fault in lockout", fault_n, 1'b1);
    desat_hi = 1'b0; supply_ok = 1'b1;
    tick(1);
    chk("R3", "gate_on after return", gate_on, 1'b1);
    pwm_in = 1'b0;
    tick(1);
    gate_low = 1'b1;
  endtask

  task automatic t_blank();
    desat_hi = 1'b1;
    tick(10);
    chk("R4", "fault_n while off", fault_n, 1'b1);
    pwm_in = 1'b1; gate_low = 1'b0;
    tick(BLANK);
    chk("R4", "gate_on in blank", gate_on, 1'b1);
    chk("R4", "fault_n in blank", fault_n, 1'b1);
    pwm_in = 1'b0;
    tick(2);
    chk("R4", "fault_n after short pulse", fault_n, 1'b1);
    chk("R4", "gate_on after short pulse", gate_on, 1'b0);
    desat_hi = 1'b0; gate_low = 1'b1;
    tick(1);
  endtask

  task automatic t_fault_clear();
    trigger_fault(1'b0, 1'b0);
    tick(3);
    chk("R6", "ssd_en held", ssd_en, 1'b1);
    chk("R6", "clamp_en before gate low", clamp_en, 1'b0);
    gate_low = 1'b1;
    tick(1);
    chk("R6", "ssd_en after gate low", ssd_en, 1'b0);
    chk("R6", "clamp_en after gate low", clamp_en, 1'b1);
    tick(MUTE + RST - 1 - 4);
    chk("R8", "fault_n one before clear", fault_n, 1'b0);
    tick(1);
    chk("R8", "fault_n cleared", fault_n, 1'b1);
    chk("R8", "drv_hiz cleared", drv_hiz, 1'b0);
    pwm_in = 1'b1; gate_low = 1'b0;
    tick(1);
    chk("R10", "gate_on after clear", gate_on, 1'b1);
    pwm_in = 1'b0;
    tick(1);
    gate_low = 1'b1;
    tick(1);
  endtask

  task automatic t_mute();
    trigger_fault(1'b0, 1'b1);
    tick(5);
    pwm_in = 1'b1;
    tick(10);
    chk("R7", "gate_on muted", gate_on, 1'b0);
    chk("R7", "drv_hiz muted", drv_hiz, 1'b1);
    chk("R7", "fault_n muted", fault_n, 1'b0);
    pwm_in = 1'b0;
    tick(MUTE + RST - 16);
    chk("R7", "fault_n one before clear", fault_n, 1'b0);
    tick(1);
    chk("R7", "fault_n clear unchanged by mute input", fault_n, 1'b1);
    tick(2);
  endtask

  task automatic t_qual_restart();
    trigger_fault(1'b0, 1'b1);
    tick(MUTE + 10);
    pwm_in = 1'b1;
    tick(1);
    chk("R9", "gate_on during qual", gate_on, 1'b0);
    pwm_in = 1'b0;
    tick(RST - 1);
    chk("R9", "fault_n before restarted clear", fault_n, 1'b0);
    tick(1);
    chk("R9", "fault_n restarted clear", fault_n, 1'b1);
    tick(2);
  endtask

  task automatic t_hold_high();
    trigger_fault(1'b1, 1'b1);
    tick(MUTE + RST + 5);
    chk("R12", "fault_n held", fault_n, 1'b0);
    chk("R12", "gate_on held off", gate_on, 1'b0);
    pwm_in = 1'b0;
    tick(RST - 1);
    chk("R12", "fault_n before clear", fault_n, 1'b0);
    tick(1);
    chk("R12", "fault_n clear", fault_n, 1'b1);
    tick(2);
  endtask

  initial begin
    t_reset();
    t_drive();
    t_supply();
    t_blank();
    t_fault_clear();
    t_mute();
    t_qual_restart();
    t_hold_high();
    finish_run();
  end

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

endmodule